// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Condition Flags

This block is the arithmetic and logic stage of a small accumulator machine. Each operation takes the accumulator, one 8-bit operand that was chosen upstream, the current condition flags and a 4-bit operation code. It computes the next accumulator value, a write strobe for it, and the next carry, zero, sign, parity and half-carry flags. The covered operations are add and subtract, each with or without carry, AND, OR, XOR, compare, four accumulator rotates, set carry, complement carry and complement accumulator.

One operation is accepted per clock while `exec_en` is high. Its results appear on the registered outputs after that clock edge. The flag outputs model a flag register: when no operation is issued, they hold their value. The surrounding datapath feeds them back as `*_i` on the next issue. Operations that must not disturb a flag copy that flag through from its input.

Top module: `alu8_core`

## Requirements
- R1: While `rst_n` is low, every output is 0: `acc_o`, `acc_we_o`, `cy_o`, `z_o`, `s_o`, `p_o` and `ac_o`.
- R2: Opcode 0 (add) gives A+B and opcode 1 (add with carry) gives A+B+`cy_i`. Both write the accumulator. Carry is the carry out of bit 7 and half-carry is the carry out of bit 3.
- R3: Opcode 2 (subtract) gives A−B and opcode 3 (subtract with borrow) gives A−B−`cy_i`, modulo 256. Both write the accumulator. Carry is 1 when a borrow out of bit 7 occurs. Half-carry is 1 when the low nibble borrows, that is when A[3:0] < B[3:0] + borrow-in.
- R4: Opcode 7 (compare) sets carry, half-carry, zero, sign and parity exactly as subtract does. It drives `acc_we_o` low and `acc_o` equal to A. So A>B gives carry 0 and zero 0, A=B gives carry 0 and zero 1, and A<B gives carry 1 and zero 0.
- R5: After an arithmetic, logic or compare operation, zero is 1 when the 8-bit result is 0, sign is result bit 7, and parity is 1 when the result holds an even number of ones.
- R6: Opcode 4 (AND), opcode 5 (XOR) and opcode 6 (OR) write the bitwise result. They clear carry. Half-carry becomes 1 after AND and 0 after XOR or OR.
- R7: Opcode 8 rotates A left with bit 7 going to both bit 0 and carry. Opcode 9 rotates A right with bit 0 going to both bit 7 and carry.
- R8: Opcode 10 rotates left through carry: bit 7 goes to carry and the old carry goes to bit 0. Opcode 11 rotates right through carry: bit 0 goes to carry and the old carry goes to bit 7.
- R9: The four rotates write the accumulator and change only carry. Zero, sign, parity and half-carry equal their inputs.
- R10: Opcode 12 sets carry to 1 and opcode 13 inverts `cy_i`. Neither writes the accumulator: `acc_o` equals A. All other flags equal their inputs.
- R11: Opcode 14 writes the bitwise inverse of A. All five flags equal their inputs.
- R12: Opcode 15 is a no-operation. `acc_we_o` is 0, `acc_o` equals A, and all flags equal their inputs.
- R13: An operation issued with `exec_en` high at a clock edge shows its results right after that edge. `acc_we_o` is high for exactly that cycle, and only for operations that write the accumulator.
- R14: After an edge with `exec_en` low, `acc_we_o` is 0 and `acc_o` and the flag outputs keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | Issue an operation this cycle |
| op_i | input | 4 | Operation code (see requirements) |
| acc_i | input | 8 | Current accumulator (A) |
| opnd_i | input | 8 | Selected operand (B) |
| cy_i | input | 1 | Current carry flag |
| z_i | input | 1 | Current zero flag |
| s_i | input | 1 | Current sign flag |
| p_i | input | 1 | Current parity flag |
| ac_i | input | 1 | Current half-carry flag |
| acc_o | output | 8 | New accumulator value |
| acc_we_o | output | 1 | Accumulator write strobe |
| cy_o | output | 1 | New carry flag |
| z_o | output | 1 | New zero flag |
| s_o | output | 1 | New sign flag |
| p_o | output | 1 | New parity flag |
| ac_o | output | 1 | New half-carry flag |

## Verification
The case that catches most errors is the one where a carry or borrow out of bit 7 and a zero result happen in the same operation. Examples are 0x80+0x80, 0xFF+0x00 with carry-in, and 0x00−0xFF−1. In these, the nibble chain, the byte chain and the zero detector all act together. The bench provokes them by sweeping every opcode over a grid of 00, 01, 0F, 10, 7F, 80 and FF for both operands with both carry values. It then adds seeded random vectors. The complete output word is judged against a bench model that uses integer arithmetic and shares no structure with the nibble-split adder.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBB = 4'd3,
    OP_AND = 4'd4,  OP_XOR = 4'd5,  OP_OR  = 4'd6,  OP_CMP = 4'd7,
    OP_RLC = 4'd8,  OP_RRC = 4'd9,  OP_RAL = 4'd10, OP_RAR = 4'd11,
    OP_STC = 4'd12, OP_CMC = 4'd13, OP_CMA = 4'd14, OP_NOP = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic cy;
    logic z;
    logic s;
    logic p;
    logic ac;
  } alu_flags_t;

  // logic unit function select
  typedef enum logic [1:0] {
    LG_AND = 2'd0, LG_XOR = 2'd1, LG_OR = 2'd2, LG_NOT = 2'd3
  } lg_sel_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  input  logic          cin_i,   // carry-in for add, borrow-in for subtract
  output logic [DW-1:0] res_o,
  output logic          cy_o,    // carry out (add) or borrow out (subtract)
  output logic          hc_o     // nibble carry (add) or nibble borrow (subtract)
);
  localparam int unsigned NW = DW / 2;
  localparam int unsigned HW = DW - NW;

  logic [DW-1:0] b_eff;
  logic          c_in;
  logic [NW:0]   lo_sum;
  logic [HW:0]   hi_sum;

  // subtract as A + ~B + ~borrow
  always_comb begin
    b_eff  = sub_i ? ~b_i : b_i;
    c_in   = sub_i ? ~cin_i : cin_i;
    lo_sum = {1'b0, a_i[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, c_in};
    hi_sum = {1'b0, a_i[DW-1:NW]} + {1'b0, b_eff[DW-1:NW]} + {{HW{1'b0}}, lo_sum[NW]};
    res_o  = {hi_sum[HW-1:0], lo_sum[NW-1:0]};
    cy_o   = sub_i ? ~hi_sum[HW] : hi_sum[HW];
    hc_o   = sub_i ? ~lo_sum[NW] : lo_sum[NW];
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  lg_sel_e       sel_i,
  output logic [DW-1:0] res_o
);
  always_comb begin
    case (sel_i)
      LG_AND:  res_o = a_i & b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      LG_OR:   res_o = a_i | b_i;
      default: res_o = ~a_i;
    endcase
  end
endmodule

// File: rtl/alu8_rotate.sv
module alu8_rotate #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic          right_i,   // 1: toward bit 0
  input  logic          thru_i,    // 1: through carry, 0: end bit wraps
  input  logic          cin_i,
  output logic [DW-1:0] res_o,
  output logic          cy_o
);
  logic [DW-1:0] rl, rr;
  logic          fill_l, fill_r;

  assign fill_l = thru_i ? cin_i : a_i[DW-1];
  assign fill_r = thru_i ? cin_i : a_i[0];
  assign rl[0]      = fill_l;
  assign rr[DW-1]   = fill_r;

  for (genvar i = 1; i < DW; i++) begin : g_shift
    assign rl[i]   = a_i[i-1];
    assign rr[i-1] = a_i[i];
  end

  assign res_o = right_i ? rr : rl;
  assign cy_o  = right_i ? a_i[0] : a_i[DW-1];
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_en,
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] opnd_i,
  input  logic          cy_i,
  input  logic          z_i,
  input  logic          s_i,
  input  logic          p_i,
  input  logic          ac_i,
  output logic [DW-1:0] acc_o,
  output logic          acc_we_o,
  output logic          cy_o,
  output logic          z_o,
  output logic          s_o,
  output logic          p_o,
  output logic          ac_o
);
  alu_op_e    op;
  alu_flags_t f_in, f_nxt, f_q;
  logic [DW-1:0] as_res, lg_res, rot_res, acc_nxt, zsp_src, acc_q;
  logic as_sub, as_cin, as_cy, as_hc, rot_cy, we_nxt, zsp_upd, we_q;
  lg_sel_e lg_sel;

  assign op   = alu_op_e'(op_i);
  assign f_in = '{cy: cy_i, z: z_i, s: s_i, p: p_i, ac: ac_i};

  assign as_sub = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
  assign as_cin = ((op == OP_ADC) || (op == OP_SBB)) ? cy_i : 1'b0;
  assign lg_sel = (op == OP_CMA) ? LG_NOT : lg_sel_e'(op_i[1:0]);

  alu8_addsub #(.DW(DW)) u_as (
    .a_i(acc_i), .b_i(opnd_i), .sub_i(as_sub), .cin_i(as_cin),
    .res_o(as_res), .cy_o(as_cy), .hc_o(as_hc)
  );

  alu8_logic #(.DW(DW)) u_lg (
    .a_i(acc_i), .b_i(opnd_i), .sel_i(lg_sel), .res_o(lg_res)
  );

  alu8_rotate #(.DW(DW)) u_rot (
    .a_i(acc_i), .right_i(op_i[0]), .thru_i(op_i[1]), .cin_i(cy_i),
    .res_o(rot_res), .cy_o(rot_cy)
  );

  // next-state
  always_comb begin
    acc_nxt = acc_i;
    we_nxt  = 1'b0;
    f_nxt   = f_in;
    zsp_upd = 1'b0;
    zsp_src = acc_i;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        acc_nxt  = as_res;
        we_nxt   = 1'b1;
        f_nxt.cy = as_cy;
        f_nxt.ac = as_hc;
        zsp_upd  = 1'b1;
        zsp_src  = as_res;
      end
      OP_CMP: begin
        f_nxt.cy = as_cy;
        f_nxt.ac = as_hc;
        zsp_upd  = 1'b1;
        zsp_src  = as_res;
      end
      OP_AND, OP_XOR, OP_OR: begin
        acc_nxt  = lg_res;
        we_nxt   = 1'b1;
        f_nxt.cy = 1'b0;
        f_nxt.ac = (op == OP_AND);
        zsp_upd  = 1'b1;
        zsp_src  = lg_res;
      end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        acc_nxt  = rot_res;
        we_nxt   = 1'b1;
        f_nxt.cy = rot_cy;
      end
      OP_STC: f_nxt.cy = 1'b1;
      OP_CMC: f_nxt.cy = ~cy_i;
      OP_CMA: begin
        acc_nxt = lg_res;
        we_nxt  = 1'b1;
      end
      default: ;
    endcase
    if (zsp_upd) begin
      f_nxt.z = (zsp_src == '0);
      f_nxt.s = zsp_src[DW-1];
      f_nxt.p = ~^zsp_src;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      f_q   <= '0;
      we_q  <= 1'b0;
    end else begin
      we_q <= exec_en & we_nxt;
      if (exec_en) begin
        acc_q <= acc_nxt;
        f_q   <= f_nxt;
      end
    end
  end

  assign acc_o    = acc_q;
  assign acc_we_o = we_q;
  assign cy_o     = f_q.cy;
  assign z_o      = f_q.z;
  assign s_o      = f_q.s;
  assign p_o      = f_q.p;
  assign ac_o     = f_q.ac;
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          exec_en,
  input logic [3:0]    op_i,
  input logic [DW-1:0] acc_i,
  input logic [DW-1:0] opnd_i,
  input logic          cy_i,
  input logic          z_i,
  input logic          s_i,
  input logic          p_i,
  input logic          ac_i,
  input logic [DW-1:0] acc_o,
  input logic          acc_we_o,
  input logic          cy_o,
  input logic          z_o,
  input logic          s_o,
  input logic          p_o,
  input logic          ac_o
);
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(exec_en && op_i == 4'd7) |-> (!acc_we_o && acc_o == $past(acc_i)));  // R4

  AST_LOGIC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(exec_en && (op_i == 4'd4 || op_i == 4'd5 || op_i == 4'd6))
      |-> (!cy_o && ac_o == $past(op_i == 4'd4)));  // R6

  AST_RLC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(exec_en && op_i == 4'd8) |-> (acc_o[0] == cy_o && cy_o == $past(acc_i[DW-1])));  // R7

  AST_ROT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(exec_en && op_i[3:2] == 2'b10)
      |-> ({z_o, s_o, p_o, ac_o} == $past({z_i, s_i, p_i, ac_i})));  // R9

  AST_CARRY_OPS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(exec_en && op_i == 4'd13) |-> (cy_o == !$past(cy_i) && !acc_we_o));  // R10

  AST_CMA_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(exec_en && op_i == 4'd14) |-> (acc_o == ~$past(acc_i) && acc_we_o));  // R11

  AST_NOP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(exec_en && op_i == 4'd15)
      |-> (!acc_we_o && {cy_o, z_o, s_o, p_o, ac_o} == $past({cy_i, z_i, s_i, p_i, ac_i})));  // R12

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(exec_en) |-> (!acc_we_o && $stable(acc_o) && $stable({cy_o, z_o, s_o, p_o, ac_o})));  // R14
endmodule

bind alu8_core alu8_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
module sim_alu8_core;
  logic       clk, rst_n, exec_en;
  logic [3:0] op_i;
  logic [7:0] acc_i, opnd_i, acc_o;
  logic       cy_i, z_i, s_i, p_i, ac_i;
  logic       acc_we_o, cy_o, z_o, s_o, p_o, ac_o;

  int nchk = 0, nfail = 0;
  bit done = 0;

  alu8_core u0 (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // expected output word: {acc, we, cy, z, s, p, ac}
  function automatic logic [13:0] model(input logic [3:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic [4:0] f);
    int r, cin;
    logic [7:0] res, fr;
    logic we, cy, z, s, p, ac, upd;
    {cy, z, s, p, ac} = f;
    res = a; fr = a; we = 0; upd = 0;
    cin = ((op == 1) || (op == 3)) ? int'(f[4]) : 0;
    case (op)
      0, 1: begin
        r = int'(a) + int'(b) + cin;
        res = r[7:0]; fr = res; we = 1; upd = 1;
        cy = (r > 255); ac = ((int'(a) % 16) + (int'(b) % 16) + cin) > 15;
      end
      2, 3, 7: begin
        r = int'(a) - int'(b) - cin;
        fr = r[7:0]; upd = 1;
        cy = (r < 0); ac = (int'(a) % 16) < ((int'(b) % 16) + cin);
        if (op != 7) begin res = fr; we = 1; end
      end
      4: begin res = a & b; fr = res; we = 1; upd = 1; cy = 0; ac = 1; end
      5: begin res = a ^ b; fr = res; we = 1; upd = 1; cy = 0; ac = 0; end
      6: begin res = a | b; fr = res; we = 1; upd = 1; cy = 0; ac = 0; end
      8:  begin res = {a[6:0], a[7]}; cy = a[7]; we = 1; end
      9:  begin res = {a[0], a[7:1]}; cy = a[0]; we = 1; end
      10: begin res = {a[6:0], f[4]}; cy = a[7]; we = 1; end
      11: begin res = {f[4], a[7:1]}; cy = a[0]; we = 1; end
      12: cy = 1;
      13: cy = ~f[4];
      14: begin res = ~a; we = 1; end
      default: ;
    endcase
    if (upd) begin
      z = (fr == 8'h00); s = fr[7];
      p = ($countones(fr) % 2) == 0;
    end
    return {res, we, cy, z, s, p, ac};
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      0, 1:    return "R2/R5";
      2, 3:    return "R3/R5";
      7:       return "R4/R5";
      4, 5, 6: return "R6/R5";
      8, 9:    return "R7/R9";
      10, 11:  return "R8/R9";
      12, 13:  return "R10";
      14:      return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [13:0] outs();
    return {acc_o, acc_we_o, cy_o, z_o, s_o, p_o, ac_o};
  endfunction

  task automatic check(input string req, input logic [13:0] exp);
    nchk++;
    if (outs() !== exp) begin
      nfail++;
      $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", req, op_i, acc_i, opnd_i, outs(), exp);
    end
  endtask

  // issue one op at a negedge, judge at the following negedge (R13)
  task automatic run_vec(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [4:0] f);
    logic [13:0] exp;
    @(negedge clk);
    exec_en = 1; op_i = op; acc_i = a; opnd_i = b;
    {cy_i, z_i, s_i, p_i, ac_i} = f;
    exp = model(op, a, b, f);
    @(negedge clk);
    check(req_of(op), exp);
  endtask

  initial begin
    automatic logic [7:0] corner[7] = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'hFF};
    logic [13:0] held;
    rst_n = 0; exec_en = 0; op_i = 0; acc_i = 8'h5A; opnd_i = 8'hA5;
    {cy_i, z_i, s_i, p_i, ac_i} = 5'b11111;
    repeat (3) @(negedge clk);
    check("R1", 14'h0);
    rst_n = 1;

    // directed: zero together with carry (R2, R5), compare ordering (R4)
    run_vec(4'd0, 8'h80, 8'h80, 5'b00000);
    run_vec(4'd1, 8'hFF, 8'h00, 5'b10000);
    run_vec(4'd3, 8'h00, 8'hFF, 5'b10000);
    run_vec(4'd7, 8'h40, 8'h40, 5'b00000);
    run_vec(4'd7, 8'h30, 8'h40, 5'b00000);

    // R13: write strobe lasts one cycle, R14: idle hold with changing inputs
    run_vec(4'd14, 8'h3C, 8'h00, 5'b01010);
    held = outs();
    @(negedge clk);
    exec_en = 0; op_i = 4'd0; acc_i = 8'h11; opnd_i = 8'h22; {cy_i, z_i, s_i, p_i, ac_i} = 5'b10101;
    @(negedge clk);
    check("R13/R14", {held[13:6], 1'b0, held[4:0]});
    @(negedge clk);
    check("R14", {held[13:6], 1'b0, held[4:0]});

    // corner grid over every opcode, both carry values
    for (int op = 0; op < 16; op++)
      for (int ia = 0; ia < 7; ia++)
        for (int ib = 0; ib < 7; ib++)
          for (int c = 0; c < 2; c++)
            run_vec(op[3:0], corner[ia], corner[ib], {c[0], 4'b0101 ^ {4{ib[0]}}});

    // seeded random
    void'($urandom(32'd2024));
    for (int n = 0; n < 3000; n++)
      run_vec(4'($urandom), 8'($urandom), 8'($urandom), 5'($urandom));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #100000000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog R13 actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule